// File: doc/BRIEF.md
# Integer Arithmetic Decode-and-Execute Stage

This block takes one 32-bit instruction word and the two register operands that belong to it. It decodes the register-register and register-immediate formats, computes the result, and reports where the result should go in the register file. It handles add and subtract, bitwise logic, shifts by a constant amount, and immediate arithmetic and logic, including building an upper-half constant. Encodings outside that set are flagged and never produce a write.

The two source indices come straight from the instruction word and are combinational. The register file can therefore return the operands in the same cycle. The result, destination index, write enable and illegal flag are registered and appear one clock after the word and its operands are presented. The write-back path can use them directly. Writes that target register 0 are dropped, so a register file with a hard-wired zero entry stays consistent.

Top module: `ide_unit`

## Requirements
- R1: `rs_idx_o` equals instruction bits [25:21] and `rt_idx_o` equals bits [20:16] in the same cycle, with no clock in between.
- R2: With opcode bits [31:26]=0, function bits [5:0]=0x21 yields opa+opb and 0x23 yields opa−opb, both wrapping modulo 2^32 without any overflow indication. The destination is the rd field, bits [15:11].
- R3: With opcode 0, function 0x25 yields opa OR opb, 0x26 yields opa XOR opb and 0x27 yields NOT(opa OR opb). The destination is rd.
- R4: With opcode 0, opb is shifted by the amount in bits [10:6], with the destination rd. Function 0x00 shifts left, 0x02 shifts right with zero fill, and 0x03 shifts right with copies of bit 31.
- R5: Opcode 0x09 yields opa plus the 16-bit immediate in bits [15:0] sign-extended, wrapping. The destination is the rt field, bits [20:16].
- R6: Opcode 0x0C yields opa AND the zero-extended immediate, and opcode 0x0D yields opa OR the zero-extended immediate. The destination is rt.
- R7: Opcode 0x0F yields the immediate in bits [31:16] of the result with zeros in bits [15:0]. The destination is rt.
- R8: Any other opcode, or opcode 0 with any other function code, sets `illegal_o`=1 and `wr_en_o`=0.
- R9: A recognised instruction whose destination index is 0 gives `wr_en_o`=0 and `illegal_o`=0. Every other recognised instruction gives `wr_en_o`=1.
- R10: The result, destination, write enable and illegal flag update on the clock edge after the inputs are presented, and hold until that edge. While synchronous reset is high, they clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| opa_i | input | 32 | Operand read at `rs_idx_o` |
| opb_i | input | 32 | Operand read at `rt_idx_o` |
| rs_idx_o | output | 5 | First source register index |
| rt_idx_o | output | 5 | Second source register index |
| wr_idx_o | output | 5 | Destination register index (registered) |
| wr_en_o | output | 1 | Register write enable (registered) |
| result_o | output | 32 | Computed result (registered) |
| illegal_o | output | 1 | Unrecognised encoding (registered) |

## Verification
The source indices are due in the same cycle as the instruction, so the bench checks them shortly after it drives the word, with no clock edge in between. Every other output is due exactly one rising edge later. Each scenario drives its inputs on a falling edge and checks the outputs on the next falling edge. One scenario also checks, before that edge, that the outputs still hold the previous instruction's values.

// File: rtl/ide_pkg.sv
package ide_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h09;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_UPPER = 6'h0F;

  localparam logic [FN_W-1:0] FN_SHL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SHRL = 6'h02;
  localparam logic [FN_W-1:0] FN_SHRA = 6'h03;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h23;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FN_W-1:0] FN_NOR  = 6'h27;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR, K_SHL, K_SHRL, K_SHRA, K_UPPER
  } op_kind_e;

  typedef struct packed {
    op_kind_e kind;
    logic     use_imm;
    logic     sign_ext;
    logic     dest_rd;
    logic     legal;
  } dec_t;
endpackage

// File: rtl/ide_decode.sv
module ide_decode
  import ide_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [FN_W-1:0]  fn_i,
  output dec_t             dec_o
);
  always_comb begin
    dec_o = '{kind: K_ADD, use_imm: 1'b0, sign_ext: 1'b0, dest_rd: 1'b0, legal: 1'b0};
    unique case (opc_i)
      OPC_REG: begin
        dec_o.dest_rd = 1'b1;
        dec_o.legal   = 1'b1;
        case (fn_i)
          FN_ADD:  dec_o.kind = K_ADD;
          FN_SUB:  dec_o.kind = K_SUB;
          FN_OR:   dec_o.kind = K_OR;
          FN_XOR:  dec_o.kind = K_XOR;
          FN_NOR:  dec_o.kind = K_NOR;
          FN_SHL:  dec_o.kind = K_SHL;
          FN_SHRL: dec_o.kind = K_SHRL;
          FN_SHRA: dec_o.kind = K_SHRA;
          default: dec_o.legal = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        dec_o.kind = K_ADD;  dec_o.use_imm = 1'b1; dec_o.sign_ext = 1'b1; dec_o.legal = 1'b1;
      end
      OPC_ANDI: begin
        dec_o.kind = K_AND;  dec_o.use_imm = 1'b1; dec_o.legal = 1'b1;
      end
      OPC_ORI: begin
        dec_o.kind = K_OR;   dec_o.use_imm = 1'b1; dec_o.legal = 1'b1;
      end
      OPC_UPPER: begin
        dec_o.kind = K_UPPER; dec_o.use_imm = 1'b1; dec_o.legal = 1'b1;
      end
      default: dec_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ide_execute.sv
module ide_execute
  import ide_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  dec_t              dec_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] src_b;

  always_comb begin
    imm_ext = dec_i.sign_ext ? {{PAD_W{imm_i[IMM_W-1]}}, imm_i} : {{PAD_W{1'b0}}, imm_i};
    src_b   = dec_i.use_imm ? imm_ext : opb_i;
  end

  always_comb begin
    case (dec_i.kind)
      K_ADD:   result_o = opa_i + src_b;
      K_SUB:   result_o = opa_i - src_b;
      K_AND:   result_o = opa_i & src_b;
      K_OR:    result_o = opa_i | src_b;
      K_XOR:   result_o = opa_i ^ src_b;
      K_NOR:   result_o = ~(opa_i | src_b);
      K_SHL:   result_o = opb_i << shamt_i;
      K_SHRL:  result_o = opb_i >> shamt_i;
      K_SHRA:  result_o = DATA_W'($signed(opb_i) >>> shamt_i);
      K_UPPER: result_o = {imm_i, {PAD_W{1'b0}}};
      default: result_o = '0;
    endcase
  end
endmodule

// File: rtl/ide_unit.sv
module ide_unit
  import ide_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  opa_i,
  input  logic [DATA_W-1:0]  opb_i,
  output logic [IDX_W-1:0]   rs_idx_o,
  output logic [IDX_W-1:0]   rt_idx_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic               wr_en_o,
  output logic [DATA_W-1:0]  result_o,
  output logic               illegal_o
);
  localparam int RT_LO = IMM_W;
  localparam int RS_LO = RT_LO + IDX_W;
  localparam int RD_LO = FN_W + IDX_W;

  dec_t              dec;
  logic [DATA_W-1:0] exe_res;
  logic [IDX_W-1:0]  dest;

  assign rs_idx_o = instr_i[RS_LO +: IDX_W];
  assign rt_idx_o = instr_i[RT_LO +: IDX_W];

  ide_decode u_dec (
    .opc_i (instr_i[INSTR_W-1 -: OPC_W]),
    .fn_i  (instr_i[FN_W-1:0]),
    .dec_o (dec)
  );

  ide_execute #(.DATA_W(DATA_W), .SH_W(IDX_W)) u_exe (
    .dec_i    (dec),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .shamt_i  (instr_i[FN_W +: IDX_W]),
    .imm_i    (instr_i[IMM_W-1:0]),
    .result_o (exe_res)
  );

  assign dest = dec.dest_rd ? instr_i[RD_LO +: IDX_W] : instr_i[RT_LO +: IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      wr_idx_o  <= '0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      result_o  <= dec.legal ? exe_res : '0;
      wr_idx_o  <= dest;
      wr_en_o   <= dec.legal && (dest != '0);
      illegal_o <= !dec.legal;
    end
  end
endmodule

// File: rtl/ide_unit_chk.sv
module ide_unit_chk
  import ide_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [INSTR_W-1:0] instr_i,
  input logic [DATA_W-1:0]  opa_i,
  input logic [DATA_W-1:0]  opb_i,
  input logic [IDX_W-1:0]   rs_idx_o,
  input logic [IDX_W-1:0]   rt_idx_o,
  input logic [IDX_W-1:0]   wr_idx_o,
  input logic               wr_en_o,
  input logic [DATA_W-1:0]  result_o,
  input logic               illegal_o
);
  // R8: an illegal word never writes
  a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !wr_en_o);

  // R9: register zero is never a write target
  a_r9_zero_dest: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_idx_o != '0));

  // R10: reset clears the registered controls
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!wr_en_o && !illegal_o && result_o == '0));

  // R4: a left shift by zero passes opb through one cycle later
  a_r4_shift_zero: assert property (@(posedge clk) disable iff (rst)
    (instr_i[31:26] == OPC_REG && instr_i[5:0] == FN_SHL && instr_i[10:6] == '0)
      |=> (result_o == $past(opb_i)));

  // R7: an upper-half constant has a zero low half
  a_r7_upper_low_zero: assert property (@(posedge clk) disable iff (rst)
    (instr_i[31:26] == OPC_UPPER) |=> (result_o[15:0] == '0 && !illegal_o));

  // R5: immediate add targets the rt field
  a_r5_addi_dest: assert property (@(posedge clk) disable iff (rst)
    (instr_i[31:26] == OPC_ADDI) |=> (wr_idx_o == $past(instr_i[20:16])));
endmodule

bind ide_unit ide_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/ide_unit_bench.sv
module ide_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [4:0]  rs_idx, rt_idx, wr_idx;
  logic        wr_en, illegal;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_unit u_ide_unit (
    .clk(clk), .rst(rst), .instr_i(instr), .opa_i(opa), .opb_i(opb),
    .rs_idx_o(rs_idx), .rt_idx_o(rt_idx), .wr_idx_o(wr_idx),
    .wr_en_o(wr_en), .result_o(result), .illegal_o(illegal)
  );

  function automatic logic [31:0] rw(input logic [4:0] s, input logic [4:0] t,
                                     input logic [4:0] d, input logic [4:0] sh,
                                     input logic [5:0] fn);
    return {6'h00, s, t, d, sh, fn};
  endfunction

  function automatic logic [31:0] iw(input logic [5:0] op, input logic [4:0] s,
                                     input logic [4:0] t, input logic [15:0] im);
    return {op, s, t, im};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, result due at the following falling edge
  task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    instr = w; opa = a; opb = b;
    @(negedge clk);
  endtask

  task automatic expect_write(input string tag, input logic [31:0] res, input logic [4:0] idx);
    chk({tag, " result"}, result, res);
    chk({tag, " wr_idx"}, {27'd0, wr_idx}, {27'd0, idx});
    chk({tag, " wr_en"}, {31'd0, wr_en}, 32'd1);
    chk({tag, " illegal"}, {31'd0, illegal}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R10 reset result", result, 32'h0);
    chk("R10 reset wr_en", {31'd0, wr_en}, 32'd0);
    chk("R10 reset illegal", {31'd0, illegal}, 32'd0);
  endtask

  task automatic t_read_idx();
    instr = rw(5'd3, 5'd7, 5'd9, 5'd0, 6'h21);
    #1;
    chk("R1 rs index", {27'd0, rs_idx}, 32'd3);
    chk("R1 rt index", {27'd0, rt_idx}, 32'd7);
    instr = iw(6'h0D, 5'd30, 5'd17, 16'h1234);
    #1;
    chk("R1 rs index imm", {27'd0, rs_idx}, 32'd30);
    chk("R1 rt index imm", {27'd0, rt_idx}, 32'd17);
    @(negedge clk);
  endtask

  task automatic t_add_sub();
    apply(rw(5'd1, 5'd2, 5'd5, 5'd0, 6'h21), 32'hFFFF_FFFF, 32'h2);
    expect_write("R2 add wrap", 32'h1, 5'd5);
    apply(rw(5'd1, 5'd2, 5'd6, 5'd0, 6'h23), 32'h0, 32'h1);
    expect_write("R2 sub wrap", 32'hFFFF_FFFF, 5'd6);
    apply(rw(5'd1, 5'd2, 5'd6, 5'd0, 6'h21), 32'h7FFF_FFFF, 32'h1);
    expect_write("R2 add no trap", 32'h8000_0000, 5'd6);
  endtask

  task automatic t_logic();
    apply(rw(5'd4, 5'd5, 5'd10, 5'd0, 6'h25), 32'hF0F0_0000, 32'h0000_0F0F);
    expect_write("R3 or", 32'hF0F0_0F0F, 5'd10);
    apply(rw(5'd4, 5'd5, 5'd11, 5'd0, 6'h26), 32'hFFFF_0000, 32'h0F0F_0F0F);
    expect_write("R3 xor", 32'hF0F0_0F0F, 5'd11);
    apply(rw(5'd4, 5'd5, 5'd12, 5'd0, 6'h27), 32'h0000_FFFF, 32'h00FF_0000);
    expect_write("R3 nor", 32'hFF00_0000, 5'd12);
  endtask

  task automatic t_shift();
    apply(rw(5'd0, 5'd8, 5'd13, 5'd31, 6'h00), 32'hDEAD_BEEF, 32'h1);
    expect_write("R4 shl 31", 32'h8000_0000, 5'd13);
    apply(rw(5'd0, 5'd8, 5'd14, 5'd4, 6'h02), 32'h0, 32'h8000_0000);
    expect_write("R4 shr logical", 32'h0800_0000, 5'd14);
    apply(rw(5'd0, 5'd8, 5'd15, 5'd4, 6'h03), 32'h0, 32'h8000_0000);
    expect_write("R4 shr arith", 32'hF800_0000, 5'd15);
    apply(rw(5'd0, 5'd8, 5'd15, 5'd0, 6'h00), 32'h0, 32'h1234_5678);
    expect_write("R4 shl 0", 32'h1234_5678, 5'd15);
  endtask

  task automatic t_addi();
    apply(iw(6'h09, 5'd2, 5'd20, 16'hFFFF), 32'h5, 32'hAAAA_AAAA);
    expect_write("R5 addi negative", 32'h4, 5'd20);
    apply(iw(6'h09, 5'd2, 5'd21, 16'h7FFF), 32'h1, 32'h0);
    expect_write("R5 addi positive", 32'h8000, 5'd21);
  endtask

  task automatic t_zext();
    apply(iw(6'h0C, 5'd3, 5'd22, 16'h8001), 32'hFFFF_FFFF, 32'h0);
    expect_write("R6 andi", 32'h0000_8001, 5'd22);
    apply(iw(6'h0D, 5'd3, 5'd23, 16'h8000), 32'h1234_0000, 32'h0);
    expect_write("R6 ori", 32'h1234_8000, 5'd23);
  endtask

  task automatic t_upper();
    apply(iw(6'h0F, 5'd9, 5'd24, 16'hABCD), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    expect_write("R7 upper", 32'hABCD_0000, 5'd24);
  endtask

  task automatic t_illegal();
    apply(iw(6'h23, 5'd1, 5'd2, 16'h0004), 32'h1, 32'h2);
    chk("R8 bad opcode illegal", {31'd0, illegal}, 32'd1);
    chk("R8 bad opcode wr_en", {31'd0, wr_en}, 32'd0);
    apply(rw(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'h1, 32'h2);
    chk("R8 bad func illegal", {31'd0, illegal}, 32'd1);
    chk("R8 bad func wr_en", {31'd0, wr_en}, 32'd0);
  endtask

  task automatic t_zero_dest();
    apply(rw(5'd1, 5'd2, 5'd0, 5'd0, 6'h21), 32'h1, 32'h2);
    chk("R9 rd zero wr_en", {31'd0, wr_en}, 32'd0);
    chk("R9 rd zero illegal", {31'd0, illegal}, 32'd0);
    apply(iw(6'h0F, 5'd0, 5'd0, 16'h1111), 32'h0, 32'h0);
    chk("R9 rt zero wr_en", {31'd0, wr_en}, 32'd0);
  endtask

  task automatic t_latency();
    apply(rw(5'd1, 5'd2, 5'd7, 5'd0, 6'h21), 32'h10, 32'h20);
    instr = rw(5'd1, 5'd2, 5'd8, 5'd0, 6'h23);
    opa = 32'h100; opb = 32'h1;
    #(CLK_PERIOD/4);
    chk("R10 held before edge", result, 32'h30);
    @(negedge clk);
    chk("R10 updated after edge", result, 32'hFF);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 reset mid-run wr_en", {31'd0, wr_en}, 32'd0);
    chk("R10 reset mid-run result", result, 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_read_idx();
    t_add_sub();
    t_logic();
    t_shift();
    t_addi();
    t_zext();
    t_upper();
    t_illegal();
    t_zero_dest();
    t_latency();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule